// File: doc/BRIEF.md
# Link-Event Application Reset Sequencer

This block produces the reset for the user application logic that sits beside a PCI Express endpoint core. It runs in the core's user clock domain and combines two kinds of inputs. The first kind is level conditions: the core's own reset-status flag, and the indication that the core has switched to the user clock. The second kind is three single-cycle, active-low link events: leaving the data-link Up state, leaving hot reset, and leaving L2 for Detect. Any of these inputs asserts an active-high application reset. The reset is held for a minimum number of cycles, set by a parameter, after the last cycle in which any trigger was seen.

A sticky one-hot cause register records which source started the most recent reset, that is, the trigger that arrived while the application reset was low. Debug software reads this register and clears individual bits with a write-one-to-clear strobe. A power-on reset input forces the application reset high and clears the cause register. The hold counter starts loaded at power-on, so release after power-on also waits the full hold.

Top module: `app_reset_sequencer`

## Requirements
- R1: While `rstN` is low, `appRst` is 1 and `causeReg` is 5'b00000. After `rstN` rises, `appRst` stays high for at least the hold length.
- R2: A link-down exit pulse (`dlDownExitN` = 0 for one cycle) sets `appRst` at the clock edge that samples it. `appRst` then stays high for exactly `HOLD_LEN` consecutive cycles and falls at the edge `HOLD_LEN` cycles after the trigger edge, provided no other trigger occurs.
- R3: A hot-reset exit pulse (`hotRstExitN` = 0 for one cycle) gives the same reset width as R2.
- R4: An L2 exit pulse (`l2ExitN` = 0 for one cycle) gives the same reset width as R2.
- R5: While `coreRstStatus` is 1, `appRst` is 1 from the next edge onward. `appRst` is released `HOLD_LEN` cycles after the last edge that sampled `coreRstStatus` high.
- R6: While `clkInUse` is 0, `appRst` is 1 from the next edge onward. `appRst` is released `HOLD_LEN` cycles after the last edge that sampled `clkInUse` low.
- R7: A trigger that arrives while `appRst` is already high reloads the hold. Release then comes `HOLD_LEN` cycles after the newest trigger.
- R8: A trigger sampled while `appRst` is 0 replaces `causeReg` with a one-hot code. The bit positions are: bit0 core reset status, bit1 clock not in use, bit2 link-down exit, bit3 hot-reset exit, bit4 L2 exit. When several triggers occur in the same cycle, the lowest bit index wins.
- R9: Triggers sampled while `appRst` is 1 leave `causeReg` unchanged.
- R10: A 1 in bit n of `causeClr` clears bit n of `causeReg` at the next edge, and a 0 leaves that bit unchanged. A capture in the same cycle takes precedence over the clear.
- R11: `HOLD_LEN` defaults to 32, and elaboration rejects any value below 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock of the endpoint core |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| coreRstStatus | input | 1 | Core reset status, active high, synchronous to clk |
| clkInUse | input | 1 | High once the core runs on the user clock |
| dlDownExitN | input | 1 | One-cycle active-low pulse on leaving data-link Up |
| hotRstExitN | input | 1 | One-cycle active-low pulse on leaving hot reset |
| l2ExitN | input | 1 | One-cycle active-low pulse on leaving L2 for Detect |
| causeClr | input | 5 | Write-one-to-clear strobe for the cause bits |
| appRst | output | 1 | Registered active-high application reset |
| causeReg | output | 5 | Sticky one-hot cause of the most recent reset |

## Verification
The assertions assume that every input is synchronous to `clk` and that each event pulse is low for a single cycle. They also assume that the level inputs change only between edges, so that a trigger is seen at exactly one known edge. The bench drives all inputs on the falling clock edge and holds each pulse for exactly one period. The quiet-cycle counter behind the minimum-hold check restarts on any trigger, so it measures the same interval the bench counts at the ports.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int NUM_SRC = 5;

  typedef enum int {
    SRC_CORE = 0,
    SRC_CLK  = 1,
    SRC_DL   = 2,
    SRC_HOT  = 3,
    SRC_L2   = 4
  } srcIdx_e;

  typedef struct packed {
    logic               reload;
    logic               capture;
    logic [NUM_SRC-1:0] srcOneHot;
  } seqStrobe_t;
endpackage

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
#(
  parameter int HOLD_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreRstStatus,
  input  logic       clkInUse,
  input  logic       dlDownExitN,
  input  logic       hotRstExitN,
  input  logic       l2ExitN,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       appRst
);
  localparam int QW = $clog2(HOLD_LEN + 1);

  logic [NUM_SRC-1:0] trigVec;
  logic               anyTrig;

  always_comb begin
    trigVec           = '0;
    trigVec[SRC_CORE] = coreRstStatus;
    trigVec[SRC_CLK]  = ~clkInUse;
    trigVec[SRC_DL]   = ~dlDownExitN;
    trigVec[SRC_HOT]  = ~hotRstExitN;
    trigVec[SRC_L2]   = ~l2ExitN;
    anyTrig           = |trigVec;
    strobe.reload     = anyTrig;
    strobe.capture    = anyTrig & ~appRst;
    strobe.srcOneHot  = trigVec & (~trigVec + 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) appRst <= 1'b1;
    else       appRst <= anyTrig | ~cntZero;
  end

  // checker: cycles since the last trigger, saturating at HOLD_LEN
  logic [QW-1:0] quietCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          quietCnt <= '0;
    else if (anyTrig)                   quietCnt <= '0;
    else if (quietCnt != QW'(HOLD_LEN)) quietCnt <= quietCnt + 1'b1;
  end

  assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(appRst) |-> quietCnt == QW'(HOLD_LEN));

  assert_dl_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dlDownExitN |=> appRst);
  assert_hot_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hotRstExitN |=> appRst);
  assert_l2_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    !l2ExitN |=> appRst);
  assert_core_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    coreRstStatus |=> appRst);
  assert_clk_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !clkInUse |=> appRst);
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (appRst && anyTrig) |=> (appRst && !cntZero));
endmodule

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int HOLD_LEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               appRst,
  input  logic [NUM_SRC-1:0] causeClr,
  output logic               cntZero,
  output logic [NUM_SRC-1:0] causeReg
);
  localparam int              CNT_W  = $clog2(HOLD_LEN);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_LEN - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdCnt <= RELOAD;
    else if (strobe.reload) holdCnt <= RELOAD;
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign cntZero = (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               causeReg <= '0;
    else if (strobe.capture) causeReg <= strobe.srcOneHot;
    else                     causeReg <= causeReg & ~causeClr;
  end

  assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(causeReg));
  assert_cause_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (causeReg == $past(strobe.srcOneHot) && $countones(causeReg) == 1));
  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (appRst && causeClr == '0) |=> $stable(causeReg));
  assert_cause_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture) |=> ((causeReg & $past(causeClr)) == '0));
endmodule

// File: rtl/app_reset_sequencer.sv
module app_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int HOLD_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreRstStatus,
  input  logic       clkInUse,
  input  logic       dlDownExitN,
  input  logic       hotRstExitN,
  input  logic       l2ExitN,
  input  logic [4:0] causeClr,
  output logic       appRst,
  output logic [4:0] causeReg
);
  // R11: the hold must cover the minimum reset width
  if (HOLD_LEN < 32) begin : g_holdTooShort
    $error("HOLD_LEN below 32 violates R11");
  end

  seqStrobe_t strobe;
  logic       cntZero;

  rsq_ctrl #(.HOLD_LEN(HOLD_LEN)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .coreRstStatus (coreRstStatus),
    .clkInUse      (clkInUse),
    .dlDownExitN   (dlDownExitN),
    .hotRstExitN   (hotRstExitN),
    .l2ExitN       (l2ExitN),
    .cntZero       (cntZero),
    .strobe        (strobe),
    .appRst        (appRst)
  );

  rsq_datapath #(.HOLD_LEN(HOLD_LEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .appRst   (appRst),
    .causeClr (causeClr),
    .cntZero  (cntZero),
    .causeReg (causeReg)
  );
endmodule

// File: tb/sim_app_reset_sequencer.sv
`timescale 1ns/1ps
module sim_app_reset_sequencer;
  localparam int HOLD = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       coreRstStatus = 1'b0;
  logic       clkInUse = 1'b1;
  logic       dlDownExitN = 1'b1;
  logic       hotRstExitN = 1'b1;
  logic       l2ExitN = 1'b1;
  logic [4:0] causeClr = '0;
  logic       appRst;
  logic [4:0] causeReg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  app_reset_sequencer #(.HOLD_LEN(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .coreRstStatus(coreRstStatus), .clkInUse(clkInUse),
    .dlDownExitN(dlDownExitN), .hotRstExitN(hotRstExitN), .l2ExitN(l2ExitN),
    .causeClr(causeClr), .appRst(appRst), .causeReg(causeReg)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts samples with appRst high, starting at the current falling edge
  task automatic measure(output int width);
    width = 0;
    while (appRst && width < 1000) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic pulseOn(input int which);
    @(negedge clk);
    case (which)
      2: dlDownExitN = 1'b0;
      3: hotRstExitN = 1'b0;
      default: l2ExitN = 1'b0;
    endcase
    @(negedge clk);
    dlDownExitN = 1'b1; hotRstExitN = 1'b1; l2ExitN = 1'b1;
  endtask

  task automatic clearAll();
    @(negedge clk); causeClr = 5'b11111;
    @(negedge clk); causeClr = 5'b00000;
  endtask

  task automatic testPowerOn();
    int w;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 appRst in reset", appRst, 1);
    check("R1 cause in reset", causeReg, 0);
    rstN = 1'b1;
    @(negedge clk);
    measure(w);
    check("R1 hold after power-on", (w >= HOLD - 1) ? 1 : 0, 1);
    check("R1 released", appRst, 0);
  endtask

  task automatic testPulse(input int which, input string req, input int code);
    int w;
    clearAll();
    pulseOn(which);
    measure(w);
    check({req, " width"}, w, HOLD);
    check("R11 width at least 32", (w >= 32) ? 1 : 0, 1);
    check({req, " cause R8"}, causeReg, code);
  endtask

  task automatic testLevelCore();
    int w;
    clearAll();
    @(negedge clk); coreRstStatus = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 held while high", appRst, 1);
    coreRstStatus = 1'b0;
    measure(w);
    check("R5 width after release", w, HOLD);
    check("R8 core cause", causeReg, 5'b00001);
  endtask

  task automatic testClockLoss();
    int w;
    clearAll();
    @(negedge clk); clkInUse = 1'b0;
    repeat (9) @(negedge clk);
    check("R6 held while clock unused", appRst, 1);
    clkInUse = 1'b1;
    measure(w);
    check("R6 width after clock", w, HOLD);
    check("R8 clock cause", causeReg, 5'b00010);
  endtask

  task automatic testReloadAndSticky();
    int w;
    clearAll();
    pulseOn(3);
    repeat (10) @(negedge clk);
    dlDownExitN = 1'b0;
    @(negedge clk);
    dlDownExitN = 1'b1;
    measure(w);
    check("R7 reload width", w, HOLD);
    check("R9 cause kept hot", causeReg, 5'b01000);
  endtask

  task automatic testClear();
    int w;
    clearAll();
    pulseOn(4);
    measure(w);
    check("R10 setup", causeReg, 5'b10000);
    @(negedge clk); causeClr = 5'b00001;
    @(negedge clk); causeClr = 5'b00000;
    check("R10 other bit ignored", causeReg, 5'b10000);
    @(negedge clk); causeClr = 5'b10000;
    @(negedge clk); causeClr = 5'b00000;
    check("R10 cleared", causeReg, 5'b00000);
  endtask

  task automatic testPriorityAndCaptureWins();
    int w;
    clearAll();
    @(negedge clk); coreRstStatus = 1'b1; l2ExitN = 1'b0;
    @(negedge clk); coreRstStatus = 1'b0; l2ExitN = 1'b1;
    measure(w);
    check("R8 priority core over L2", causeReg, 5'b00001);
    @(negedge clk); dlDownExitN = 1'b0; causeClr = 5'b11111;
    @(negedge clk); dlDownExitN = 1'b1; causeClr = 5'b00000;
    check("R10 capture beats clear", causeReg, 5'b00100);
    measure(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    testPowerOn();
    testPulse(2, "R2 link-down", 5'b00100);
    testPulse(3, "R3 hot-reset", 5'b01000);
    testPulse(4, "R4 L2 exit", 5'b10000);
    testLevelCore();
    testClockLoss();
    testReloadAndSticky();
    testClear();
    testPriorityAndCaptureWins();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule